// File: doc/BRIEF.md
# Multi-Source System Reset Funnel

This block gathers every reset request of a small microcontroller into one system reset. The nine sources are power-on, supply monitor, the external active-low reset pin, a missing-clock one-shot, the watchdog, a software request, a comparator trip, an errant flash access and a USB bus-voltage transition. Three of these sources are gated by their own enable inputs. Any enabled request asserts the system reset in the same cycle, without waiting for a clock edge. Each request is also passed through a synchroniser. The reset is then held for a fixed stretch of clocks after the last synchronised request goes away, and it is released on a clock edge.

While reset is active, the block forces the port latches high in open-drain mode. For power-on and supply-monitor resets it also pulls the shared reset pin low through an open-drain enable. When reset is released, it gives downstream register files a one-cycle default-load strobe. Alongside the strobe it presents the program-counter start address, the clock-source choice and the watchdog defaults. A one-hot cause register keeps the source that started the most recent reset, which lets software tell the possible causes apart.

Top module: `rst_funnel`

## Requirements
- R1: Any enabled request, or `por_i` high, drives `sys_rst_o` high in the same cycle, before any clock edge.
- R2: The missing-clock, watchdog and comparator requests have no effect unless `clk_loss_en_i`, `wdt_en_i` and `cmp_rst_en_i` respectively are high.
- R3: After a request held for L cycles, `sys_rst_o` falls on the (L+18)th rising edge after the request rose (2 synchroniser stages plus 16 stretch clocks). After `por_i` falls, `sys_rst_o` falls on the 16th rising edge.
- R4: `rst_pin_drive_o` is high, pulling the pin low, during a reset caused by power-on or the supply monitor. It falls on the same edge as `sys_rst_o`, and it never goes high outside a reset.
- R5: The pin read low (`rst_pin_i` = 0) while the block is not driving it counts as an external-pin request.
- R6: While `sys_rst_o` is high, `port_force_o` and `port_od_o` are high and `port_val_o` is 8'hFF. `weak_pu_o` is high at all times.
- R7: `load_dflt_o` pulses for exactly one cycle, starting on the edge where `sys_rst_o` falls. During the pulse, `pc_load_o` is 16'h0000, `clk_sel_o` is 2'b01 (internal oscillator), `wdt_en_o` is 1 and `wdt_div_o` is 2'b01 (system clock divided by 12). Outside the pulse all four are zero.
- R8: `cause_o` is one-hot, with bit 0 power-on, 1 supply monitor, 2 pin, 3 missing clock, 4 watchdog, 5 software, 6 comparator, 7 flash error and 8 bus-voltage event. At reset entry the lowest-numbered active source is captured.
- R9: A power-on reset sets `cause_o` to 9'h001, which clears every other flag.
- R10: A request that arrives while the reset is still being held restarts the stretch window and leaves `cause_o` unchanged.
- R11: A single-cycle pulse on `clk_loss_i` produces a full-length reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on request; also clears the block's state |
| vmon_i | input | 1 | Supply monitor request |
| rst_pin_i | input | 1 | Sampled level of the shared active-low reset pin |
| clk_loss_i | input | 1 | Missing-clock one-shot pulse |
| clk_loss_en_i | input | 1 | Enable for the missing-clock request |
| wdt_req_i | input | 1 | Watchdog expiry request |
| wdt_en_i | input | 1 | Enable for the watchdog request |
| sw_req_i | input | 1 | Software reset request |
| cmp_req_i | input | 1 | Comparator trip request |
| cmp_rst_en_i | input | 1 | Enable for the comparator request |
| flash_err_i | input | 1 | Errant flash access request |
| vbus_evt_i | input | 1 | USB bus-voltage transition request |
| sys_rst_o | output | 1 | System reset, active high |
| rst_pin_drive_o | output | 1 | Open-drain enable that pulls the reset pin low |
| load_dflt_o | output | 1 | One-cycle default-load strobe at reset release |
| pc_load_o | output | 16 | Program-counter start address during the strobe |
| clk_sel_o | output | 2 | Clock-source default during the strobe |
| wdt_en_o | output | 1 | Watchdog enable default during the strobe |
| wdt_div_o | output | 2 | Watchdog clock-divider default during the strobe |
| port_force_o | output | 1 | Forces the port latches |
| port_val_o | output | 8 | Forced port latch value |
| port_od_o | output | 1 | Open-drain mode for the ports |
| weak_pu_o | output | 1 | Weak pull-up enable |
| cause_o | output | 9 | One-hot cause of the last reset |

## Verification
The bench builds the block with its defaults: two synchroniser stages and a stretch of 16 clocks. With these values, the release edge of every reset falls at a cycle that can be counted directly from the stimulus. A request that arrives partway through a stretch can be placed at a known offset, so that the restarted window and the unchanged cause are both observed. The pin is modelled as an open-drain wire. This makes it possible to show that the block's own pull-down never reads back as an external request.

// File: rtl/rst_funnel_pkg.sv
package rst_funnel_pkg;

    localparam int NUM_SRC   = 9;
    // Bit positions inside the request and cause vectors; lower index wins.
    localparam int IDX_POR   = 0;
    localparam int IDX_VMON  = 1;
    localparam int IDX_PIN   = 2;
    localparam int IDX_MCD   = 3;
    localparam int IDX_WDT   = 4;
    localparam int IDX_SW    = 5;
    localparam int IDX_CMP   = 6;
    localparam int IDX_FLASH = 7;
    localparam int IDX_VBUS  = 8;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        CLK_NONE     = 2'b00,
        CLK_INTERNAL = 2'b01,
        CLK_EXTERNAL = 2'b10,
        CLK_MULT     = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        WDT_DIV_NONE = 2'b00,
        WDT_DIV_12   = 2'b01,
        WDT_DIV_4    = 2'b10,
        WDT_DIV_1    = 2'b11
    } wdt_div_e;

    typedef struct packed {
        logic [15:0] pc;
        clk_src_e    clk_sel;
        logic        wdt_en;
        wdt_div_e    wdt_div;
    } exit_dflt_t;

    localparam exit_dflt_t EXIT_DFLT = '{
        pc:      16'h0000,
        clk_sel: CLK_INTERNAL,
        wdt_en:  1'b1,
        wdt_div: WDT_DIV_12
    };

    localparam logic [7:0] PORT_RESET_VAL = 8'hFF;

    // One-hot of the lowest-index set bit.
    function automatic src_vec_t pick_first(input src_vec_t v);
        src_vec_t r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = src_vec_t'(1) << i;
        end
        return r;
    endfunction

endpackage

// File: rtl/rst_req_sync.sv
module rst_req_sync
    import rst_funnel_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     clr,
    input  src_vec_t raw_i,
    output src_vec_t sync_o,
    output src_vec_t pend_o
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic [STAGES-1:0] sh;

        always_ff @(posedge clk) begin
            if (clr) sh <= '0;
            else     sh <= {sh[STAGES-2:0], raw_i[s]};
        end

        assign sync_o[s] = sh[STAGES-1];
        assign pend_o[s] = |sh;
    end

endmodule

// File: rtl/rst_stretch.sv
module rst_stretch
    import rst_funnel_pkg::*;
#(
    parameter int STRETCH = 16
) (
    input  logic     clk,
    input  logic     por_i,
    input  src_vec_t req_s_i,
    output logic     busy_o,
    output logic     load_o,
    output logic     drive_o
);

    localparam int CNT_W = $clog2(STRETCH + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             any_s;

    assign any_s = |req_s_i;

    always_ff @(posedge clk) begin
        if (por_i) begin
            busy_o  <= 1'b1;
            cnt_q   <= CNT_W'(STRETCH);
            drive_o <= 1'b1;
            load_o  <= 1'b0;
        end else begin
            load_o <= 1'b0;
            if (any_s) begin
                busy_o <= 1'b1;
                cnt_q  <= CNT_W'(STRETCH);
                if (req_s_i[IDX_VMON]) drive_o <= 1'b1;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_o  <= 1'b0;
                    drive_o <= 1'b0;
                    load_o  <= 1'b1;
                end
            end
        end
    end

    assert_req_holds_R3: assert property (@(posedge clk) disable iff (por_i)
        any_s |=> busy_o);
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (por_i)
        load_o |=> !load_o);
    assert_strobe_at_release_R7: assert property (@(posedge clk) disable iff (por_i)
        $fell(busy_o) |-> load_o);
    assert_drive_within_reset_R4: assert property (@(posedge clk) disable iff (por_i)
        drive_o |-> busy_o);

endmodule

// File: rtl/rst_cause.sv
module rst_cause
    import rst_funnel_pkg::*;
(
    input  logic     clk,
    input  logic     por_i,
    input  logic     entry_i,
    input  src_vec_t req_s_i,
    output src_vec_t cause_o
);

    always_ff @(posedge clk) begin
        if (por_i)        cause_o <= src_vec_t'(1) << IDX_POR;
        else if (entry_i) cause_o <= pick_first(req_s_i);
    end

    assert_cause_onehot_R8: assert property (@(posedge clk) disable iff (por_i)
        $countones(cause_o) == 1);
    assert_cause_held_R10: assert property (@(posedge clk) disable iff (por_i)
        !entry_i |=> $stable(cause_o));

endmodule

// File: rtl/rst_funnel.sv
module rst_funnel
    import rst_funnel_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int STRETCH_CYCLES = 16
) (
    input  logic        clk,
    input  logic        por_i,
    input  logic        vmon_i,
    input  logic        rst_pin_i,
    input  logic        clk_loss_i,
    input  logic        clk_loss_en_i,
    input  logic        wdt_req_i,
    input  logic        wdt_en_i,
    input  logic        sw_req_i,
    input  logic        cmp_req_i,
    input  logic        cmp_rst_en_i,
    input  logic        flash_err_i,
    input  logic        vbus_evt_i,
    output logic        sys_rst_o,
    output logic        rst_pin_drive_o,
    output logic        load_dflt_o,
    output logic [15:0] pc_load_o,
    output logic [1:0]  clk_sel_o,
    output logic        wdt_en_o,
    output logic [1:0]  wdt_div_o,
    output logic        port_force_o,
    output logic [7:0]  port_val_o,
    output logic        port_od_o,
    output logic        weak_pu_o,
    output logic [8:0]  cause_o
);

    src_vec_t   raw;
    src_vec_t   req_s;
    src_vec_t   pend;
    src_vec_t   cause;
    logic       busy;
    logic       load;
    logic       drive;
    exit_dflt_t dflt;

    always_comb begin
        raw            = '0;
        raw[IDX_POR]   = por_i;
        raw[IDX_VMON]  = vmon_i;
        raw[IDX_PIN]   = !rst_pin_i && !drive;
        raw[IDX_MCD]   = clk_loss_i && clk_loss_en_i;
        raw[IDX_WDT]   = wdt_req_i && wdt_en_i;
        raw[IDX_SW]    = sw_req_i;
        raw[IDX_CMP]   = cmp_req_i && cmp_rst_en_i;
        raw[IDX_FLASH] = flash_err_i;
        raw[IDX_VBUS]  = vbus_evt_i;
    end

    rst_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .clr    (por_i),
        .raw_i  (raw),
        .sync_o (req_s),
        .pend_o (pend)
    );

    rst_stretch #(.STRETCH(STRETCH_CYCLES)) u_stretch (
        .clk     (clk),
        .por_i   (por_i),
        .req_s_i (req_s),
        .busy_o  (busy),
        .load_o  (load),
        .drive_o (drive)
    );

    rst_cause u_cause (
        .clk     (clk),
        .por_i   (por_i),
        .entry_i (!busy && (|req_s)),
        .req_s_i (req_s),
        .cause_o (cause)
    );

    // Assert at once from the raw requests, hold through sync and stretch.
    assign sys_rst_o       = (|raw) || (|pend) || busy;
    assign rst_pin_drive_o = drive;
    assign load_dflt_o     = load;

    assign dflt      = load ? EXIT_DFLT : '0;
    assign pc_load_o = dflt.pc;
    assign clk_sel_o = dflt.clk_sel;
    assign wdt_en_o  = dflt.wdt_en;
    assign wdt_div_o = dflt.wdt_div;

    assign port_force_o = sys_rst_o;
    assign port_val_o   = sys_rst_o ? PORT_RESET_VAL : 8'h00;
    assign port_od_o    = sys_rst_o;
    assign weak_pu_o    = 1'b1;
    assign cause_o      = cause;

    assert_pin_drive_in_reset_R4: assert property (@(posedge clk) disable iff (por_i)
        rst_pin_drive_o |-> sys_rst_o);
    assert_defaults_with_strobe_R7: assert property (@(posedge clk) disable iff (por_i)
        load_dflt_o |-> !sys_rst_o || (|raw));

endmodule

// File: tb/rst_funnel_test.sv
module rst_funnel_test;
    import rst_funnel_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       por = 1'b1;
    logic [8:0] stim = '0;
    logic       mcd_en = 1'b0, wdt_en = 1'b0, cmp_en = 1'b0;
    logic       sys_rst, drive, load, wdt_en_d, port_force, port_od, weak_pu;
    logic [15:0] pc;
    logic [1:0] clk_sel, wdt_div;
    logic [7:0] port_val;
    logic [8:0] cause;
    logic       pin;

    int checks = 0;
    int errors = 0;

    // Open-drain pin: low when the block or the outside world pulls it.
    assign pin = !(drive || stim[2]);

    rst_funnel uut (
        .clk(clk), .por_i(por), .vmon_i(stim[1]), .rst_pin_i(pin),
        .clk_loss_i(stim[3]), .clk_loss_en_i(mcd_en),
        .wdt_req_i(stim[4]), .wdt_en_i(wdt_en), .sw_req_i(stim[5]),
        .cmp_req_i(stim[6]), .cmp_rst_en_i(cmp_en),
        .flash_err_i(stim[7]), .vbus_evt_i(stim[8]),
        .sys_rst_o(sys_rst), .rst_pin_drive_o(drive), .load_dflt_o(load),
        .pc_load_o(pc), .clk_sel_o(clk_sel), .wdt_en_o(wdt_en_d),
        .wdt_div_o(wdt_div), .port_force_o(port_force), .port_val_o(port_val),
        .port_od_o(port_od), .weak_pu_o(weak_pu), .cause_o(cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_release_outputs();
        chk("R3 released", sys_rst, 0);
        chk("R7 strobe", load, 1);
        chk("R7 pc", pc, 16'h0000);
        chk("R7 clk_sel", clk_sel, 2'b01);
        chk("R7 wdt_en", wdt_en_d, 1);
        chk("R7 wdt_div", wdt_div, 2'b01);
        chk("R6 no force", port_force, 0);
        chk("R6 weak pull-up after", weak_pu, 1);
        chk("R4 pin released", drive, 0);
        tick();
        chk("R7 strobe single", load, 0);
        chk("R7 clk_sel off", clk_sel, 2'b00);
    endtask

    task automatic t_por();
        por = 1'b1;
        #1 chk("R1 por immediate", sys_rst, 1);
        tick(); tick();
        chk("R9 cause por", cause, 9'h001);
        chk("R4 pin driven", drive, 1);
        chk("R6 force", port_force, 1);
        chk("R6 value", port_val, 8'hFF);
        chk("R6 open drain", port_od, 1);
        chk("R6 weak pull-up", weak_pu, 1);
        por = 1'b0;
        repeat (15) tick();
        chk("R3 por hold", sys_rst, 1);
        tick();
        check_release_outputs();
    endtask

    task automatic t_req(input logic [8:0] m, input int len, input logic [8:0] exp_cause,
                         input logic exp_drive, input string tag);
        stim = m;
        #1 chk({tag, " R1 immediate"}, sys_rst, 1);
        repeat (len) tick();
        stim = '0;
        repeat (16) tick();
        chk({tag, " R8 cause"}, cause, exp_cause);
        chk({tag, " R4 drive"}, drive, exp_drive);
        tick();
        chk({tag, " R3 hold"}, sys_rst, 1);
        tick();
        check_release_outputs();
    endtask

    task automatic t_gated(input logic [8:0] m, input logic [8:0] prev, input string tag);
        stim = m;
        for (int i = 0; i < 4; i++) begin
            #1 chk({tag, " R2 gated"}, sys_rst, 0);
            tick();
        end
        stim = '0;
        repeat (4) tick();
        chk({tag, " R2 gated no late reset"}, sys_rst, 0);
        chk({tag, " R2 cause kept"}, cause, prev);
    endtask

    task automatic t_extend();
        stim = 9'h020;
        tick();
        stim = '0;
        repeat (9) tick();
        stim = 9'h080;
        tick();
        stim = '0;
        repeat (17) tick();
        chk("R10 extended hold", sys_rst, 1);
        chk("R10 cause unchanged", cause, 9'h020);
        tick();
        check_release_outputs();
    endtask

    initial begin
        tick();
        t_por();
        t_req(9'h002, 2, 9'h002, 1'b1, "vmon R4");
        repeat (6) tick();
        chk("R5 no self-trigger from own drive", sys_rst, 0);
        t_req(9'h004, 1, 9'h004, 1'b0, "pin R5");
        t_gated(9'h010, 9'h004, "wdt");
        t_gated(9'h040, 9'h004, "cmp");
        t_gated(9'h008, 9'h004, "mcd");
        mcd_en = 1'b1; wdt_en = 1'b1; cmp_en = 1'b1;
        t_req(9'h008, 1, 9'h008, 1'b0, "mcd pulse R11");
        t_req(9'h110, 1, 9'h010, 1'b0, "wdt over vbus R8");
        t_req(9'h0A0, 2, 9'h020, 1'b0, "sw over flash R8");
        t_req(9'h040, 1, 9'h040, 1'b0, "cmp enabled R2");
        t_req(9'h100, 3, 9'h100, 1'b0, "vbus R8");
        t_extend();
        t_por();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule